// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block supplies the value a host sees when it reads a flash-style memory while an internal program or erase is running. Once an operation has been launched, reads no longer return array data. They return a status byte instead. The top bit (the poll bit) reports the inverse of the top bit of the byte being written, or zero during any erase. The next bit down (the toggle bit) flips on every completed read. The remaining bits read as zero. When the operation ends, reads return true array data again, a one-cycle completion pulse is raised, and a new operation may be launched.

Real program times are microseconds and erase times are milliseconds. These are stood in for by busy durations in clock cycles, supplied on input ports and captured when the operation is launched. A byte program lasts the program duration. A sector erase lasts the sector duration. A chip erase first runs a program-to-zero pass of the program duration and then erases `NUM_SECT` sectors one after another, each lasting the sector duration. A duration of zero is treated as one cycle. The launch pulse stands for the end of the last write strobe of a command sequence. Command decoding and the array itself lie outside this block.

Top module: `op_status_reporter`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `done` are 0 and `rd_data` equals `array_data`.
- R2: A `start` pulse sampled while idle with `op_kind` = 2'b00 (byte program) raises `busy` on the next cycle, and `busy` then stays high for max(`dur_prog`,1) cycles.
- R3: With `op_kind` = 2'b01 (sector erase), `busy` stays high for max(`dur_sect`,1) cycles.
- R4: With `op_kind` = 2'b10 (chip erase), `busy` stays high for max(`dur_prog`,1) + `NUM_SECT`·max(`dur_sect`,1) cycles.
- R5: While a byte program is busy, `rd_data[DATA_W-1]` (the poll bit) equals the inverse of `prog_msb` as sampled at launch.
- R6: While either kind of erase is busy, the poll bit reads 0.
- R7: The toggle bit, `rd_data[DATA_W-2]`, reads 0 on the first busy cycle of every operation. It inverts after each cycle in which `rd_req` is high while busy.
- R8: While busy, the toggle bit holds its value across cycles without `rd_req`.
- R9: While busy, `rd_data[DATA_W-3:0]` reads all zeros.
- R10: On the first idle cycle after an operation, `done` is high for exactly one cycle. From that cycle on, `rd_data` equals `array_data`.
- R11: A `start` sampled while busy has no effect on the running operation's length or poll bit. A `start` with `op_kind` = 2'b11 is ignored entirely.
- R12: Durations and `prog_msb` are captured at launch. Changing them during an operation has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle launch pulse at the end of a command sequence |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| prog_msb | input | 1 | Top data bit of the byte being programmed |
| dur_prog | input | CNT_W | Program (and pre-clear pass) duration in cycles |
| dur_sect | input | CNT_W | Per-sector erase duration in cycles |
| rd_req | input | 1 | High for one cycle per completed host read |
| array_data | input | DATA_W | True data from the array for the current read |
| busy | output | 1 | Operation in progress (sideband) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Data returned to the host |

## Verification
All three operation kinds are swept over every pair of small program and sector durations, including zero. Zero against one separates the clamp from an off-by-one in the counter. Unequal durations expose a chip erase that uses the wrong duration or the wrong sector count. Read spacing is varied: no reads, back-to-back reads, and reads every third cycle. These separate a toggle that advances per read from one that advances per clock, and an odd number of reads before completion shows whether the toggle restarts at zero on the next launch. Half the runs disturb the durations, the programmed bit and `start` mid-operation, and the reserved code is launched from idle. Together these show that launch-time capture and launch gating hold.

// File: rtl/op_status_pkg.sv
// Shared types for the operation status reporter.
package op_status_pkg;
    // Operation kinds as presented at the launch port.
    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_RSVD = 2'b11
    } op_kind_e;

    // Phase of the running operation.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_PROG  = 2'b01,
        PH_CLEAR = 2'b10,
        PH_ERASE = 2'b11
    } phase_e;
endpackage

// File: rtl/op_timer.sv
// Operation timer: accepts a launch while idle, then counts the busy window.
// A chip erase runs a clear pass followed by NUM_SECT sector phases.
// Assumes durations are in clock cycles; a zero duration counts as one.
module op_timer
    import op_status_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_SECT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_kind_e         kind,
    input  logic [CNT_W-1:0] dur_prog,
    input  logic [CNT_W-1:0] dur_sect,
    output logic             accept,
    output logic             busy,
    output logic             done
);
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam logic [SECT_W-1:0] LAST_SECT = SECT_W'(NUM_SECT - 1);

    phase_e             phase;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   sect_len;
    logic [SECT_W-1:0]  sect_left;
    logic [CNT_W-1:0]   prog_len_m1;
    logic [CNT_W-1:0]   sect_len_m1;

    // Clamp durations to at least one cycle and form the reload values.
    always_comb begin
        prog_len_m1 = (dur_prog == '0) ? '0 : dur_prog - 1'b1;
        sect_len_m1 = (dur_sect == '0) ? '0 : dur_sect - 1'b1;
    end

    assign busy   = (phase != PH_IDLE);
    assign accept = start && !busy && (kind != OP_RSVD);

    // Phase sequencing and down-counting of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            sect_len  <= '0;
            sect_left <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (accept) begin
                    sect_len <= sect_len_m1;
                    case (kind)
                        OP_PROG: begin
                            phase     <= PH_PROG;
                            cnt       <= prog_len_m1;
                            sect_left <= '0;
                        end
                        OP_SECT: begin
                            phase     <= PH_ERASE;
                            cnt       <= sect_len_m1;
                            sect_left <= '0;
                        end
                        default: begin
                            phase     <= PH_CLEAR;
                            cnt       <= prog_len_m1;
                            sect_left <= LAST_SECT;
                        end
                    endcase
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (phase == PH_CLEAR) begin
                phase <= PH_ERASE;
                cnt   <= sect_len;
            end else if ((phase == PH_ERASE) && (sect_left != '0)) begin
                sect_left <= sect_left - 1'b1;
                cnt       <= sect_len;
            end else begin
                phase <= PH_IDLE;
                done  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/op_toggle.sv
// Toggle state: cleared on every launch, inverted by each read while busy.
// Assumes rd_req is a single-cycle pulse per completed host read.
module op_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic busy,
    input  logic rd_req,
    output logic tog
);
    // Restart at zero on launch; advance only on reads during an operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (accept)
            tog <= 1'b0;
        else if (busy && rd_req)
            tog <= ~tog;
    end
endmodule

// File: rtl/op_status_mux.sv
// Read path: substitutes the status pattern for array data while busy.
// The poll value is captured at launch so later input changes do not matter.
module op_status_mux
    import op_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  op_kind_e          kind,
    input  logic              prog_msb,
    input  logic              busy,
    input  logic              tog,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LOW_W = DATA_W - 2;

    logic poll_bit;

    // Capture the poll value: inverted data bit for program, zero for erase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            poll_bit <= 1'b0;
        else if (accept)
            poll_bit <= (kind == OP_PROG) ? ~prog_msb : 1'b0;
    end

    // Select status pattern or true data for the host.
    always_comb begin
        if (busy)
            rd_data = {poll_bit, tog, {LOW_W{1'b0}}};
        else
            rd_data = array_data;
    end
endmodule

// File: rtl/op_status_reporter.sv
// Top of the operation status reporter: timer, toggle state and read mux.
// Assumes start marks the end of an accepted command sequence and that
// DATA_W is at least 3 (poll bit, toggle bit, zero field).
module op_status_reporter
    import op_status_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    parameter int NUM_SECT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic              prog_msb,
    input  logic [CNT_W-1:0]  dur_prog,
    input  logic [CNT_W-1:0]  dur_sect,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] array_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    op_kind_e kind;
    logic     accept;
    logic     tog;

    assign kind = op_kind_e'(op_kind);

    op_timer #(.CNT_W(CNT_W), .NUM_SECT(NUM_SECT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (kind),
        .dur_prog (dur_prog),
        .dur_sect (dur_sect),
        .accept   (accept),
        .busy     (busy),
        .done     (done)
    );

    op_toggle u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .busy   (busy),
        .rd_req (rd_req),
        .tog    (tog)
    );

    op_status_mux #(.DATA_W(DATA_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .kind       (kind),
        .prog_msb   (prog_msb),
        .busy       (busy),
        .tog        (tog),
        .array_data (array_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/op_status_reporter_chk.sv
// Temporal checks on the status reporter's ports, bound to the top module.
module op_status_reporter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op_kind,
    input logic              rd_req,
    input logic [DATA_W-1:0] array_data,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data
);
    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_kind != 2'b11) |=> busy);
    // R11
    rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_kind == 2'b11) |=> !busy);
    // R11
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R7
    toggle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rd_data[DATA_W-2] == 1'b0));
    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(rd_req)) |-> (rd_data[DATA_W-2] != $past(rd_data[DATA_W-2])));
    // R8
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(rd_req)) |-> $stable(rd_data[DATA_W-2]));
    // R5
    poll_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_data[DATA_W-1]));
    // R9
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data[DATA_W-3:0] == '0));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_data == array_data));
endmodule

bind op_status_reporter op_status_reporter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_op_status_reporter.sv
`timescale 1ns/1ps
module tb_op_status_reporter;
    localparam int DW = 8;
    localparam int CW = 16;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    op_kind;
    logic          prog_msb;
    logic [CW-1:0] dur_prog;
    logic [CW-1:0] dur_sect;
    logic          rd_req;
    logic [DW-1:0] array_data;
    logic          busy;
    logic          done;
    logic [DW-1:0] rd_data;

    int  total = 0;
    int  bad   = 0;
    bit  ended = 0;

    always #10 clk = ~clk;

    op_status_reporter #(.DATA_W(DW), .CNT_W(CW), .NUM_SECT(NS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .prog_msb(prog_msb), .dur_prog(dur_prog), .dur_sect(dur_sect),
        .rd_req(rd_req), .array_data(array_data),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One launch of the given kind; rmod = read spacing (0: no reads).
    task automatic run_op(input logic [1:0] op, input logic msb, input int dp,
                          input int ds, input int rmod, input bit disturb);
        int dpe = (dp == 0) ? 1 : dp;
        int dse = (ds == 0) ? 1 : ds;
        int exp_len = (op == 2'b00) ? dpe : (op == 2'b01) ? dse : dpe + NS * dse;
        int n = 0;
        bit tog = 0;
        logic exp7 = (op == 2'b00) ? ~msb : 1'b0;
        start = 1'b1; op_kind = op; prog_msb = msb;
        dur_prog = CW'(dp); dur_sect = CW'(ds); rd_req = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after launch", int'(busy), 1);
        while (busy && n < 2000) begin
            n++;
            // R5 R6 poll bit
            chk(rd_data[DW-1] == exp7, (op == 2'b00) ? "R5 poll bit" : "R6 poll bit",
                int'(rd_data[DW-1]), int'(exp7));
            // R7 R8 toggle bit
            chk(rd_data[DW-2] == tog, "R7/R8 toggle bit", int'(rd_data[DW-2]), int'(tog));
            chk(rd_data[DW-3:0] == '0, "R9 low bits", int'(rd_data[DW-3:0]), 0);
            rd_req = (rmod != 0) && (n % rmod == 0);
            if (rd_req) tog = ~tog;
            if (disturb) begin
                // R11 R12 mid-operation disturbance
                dur_prog = CW'(dp + 7); dur_sect = CW'(ds + 5);
                prog_msb = ~msb;
                start    = (n == 2);
                op_kind  = (n == 2) ? 2'b00 : op;
            end
            array_data = DW'(n * 29 + 3);
            @(negedge clk);
            start = 1'b0;
        end
        rd_req = 1'b0;
        chk(n == exp_len, (op == 2'b00) ? "R2 length" : (op == 2'b01) ? "R3 length" : "R4 length",
            n, exp_len);
        if (disturb) chk(n == exp_len, "R11/R12 length under disturbance", n, exp_len);
        chk(done == 1'b1, "R10 done raised", int'(done), 1);
        chk(rd_data == array_data, "R10 true data", int'(rd_data), int'(array_data));
        array_data = DW'(dp * 37 + ds * 11 + 5);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single", int'(done), 0);
        chk(rd_data == array_data, "R10 true data follows", int'(rd_data), int'(array_data));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    // Stimulus and checks.
    initial begin
        rst_n = 1'b0; start = 1'b0; op_kind = 2'b00; prog_msb = 1'b0;
        dur_prog = '0; dur_sect = '0; rd_req = 1'b0; array_data = 8'hA5;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        chk(rd_data == array_data, "R1 data in reset", int'(rd_data), int'(array_data));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);
        array_data = 8'h3C;
        #1;
        chk(rd_data == 8'h3C, "R1 data passes through", int'(rd_data), 8'h3C);

        // Reserved code from idle is ignored (R11).
        start = 1'b1; op_kind = 2'b11; dur_prog = 16'd3;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R11 reserved launch ignored", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0 && rd_data == array_data, "R11 reserved no effect",
            int'(rd_data), int'(array_data));

        for (int op = 0; op < 3; op++)
            for (int dp = 0; dp < 4; dp++)
                for (int ds = 0; ds < 4; ds++)
                    for (int rm = 0; rm < 3; rm++)
                        run_op(2'(op), logic'((dp + ds + rm) % 2), dp, ds,
                               (rm == 2) ? 3 : rm, bit'((dp + ds) % 2));
        finish_run();
    end
endmodule